// File: doc/BRIEF.md
# Start-Bit Framed Serial Display Latch

This block takes a serial word on two wires, data and clock, and turns it into a bank of latched parallel outputs. There is no load strobe. Each word starts with a logic-1 marker bit. The block shifts bits in on rising edges of the serial clock. When the marker has moved through the whole register, the data bits behind it are copied into the output latches in one system-clock pulse. On the next falling serial edge the shift stages are cleared, so the next word can follow straight away.

The serial pins are oversampled by a faster system clock through two-flop synchronizers. A parameter selects one of two variants. In the full variant all 35 data bits drive outputs. In the reduced variant only 34 outputs exist, and a data-enable input allows shifting only while it is high. An active-low power-on reset clears both the shift stages and the latches.

Top module: `serial_frame_latch`

## Requirements
- R1: While `rstN` is low, and after it is released, every bit of `dispOut` reads 0 until the first completed word is loaded.
- R2: A word is a 1 followed by 35 data bits, 36 rising serial edges in all. After the 36th rising edge, `dispOut[k-1]` equals data bit k, counted from 1 for the first bit after the marker. A 1 drives the output high.
- R3: Between loads, `dispOut` holds steady. This includes the time while a new word is being shifted in.
- R4: A word cut short, with fewer than 36 rising edges, loads nothing and leaves `dispOut` unchanged.
- R5: After a load, the shift stages are cleared on the next falling serial edge. A new word may start on the very next rising edge, and it loads only its own bits.
- R6: Each completed word produces exactly one load pulse, one system clock long.
- R7: When `NUM_OUT` = 34, rising serial edges seen while `dataEn` is low are ignored. Such edges neither shift nor load, and a word may be spread across them.
- R8: When `NUM_OUT` = 35, `dataEn` has no effect. A word sent with it held low still loads.
- R9: When `NUM_OUT` = 34, data bit 35 is shifted but drives no output. Bits 1 to 34 still land on `dispOut[0]` to `dispOut[33]`.
- R10: A load turns off every output whose new bit is 0, even if it was on before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| serClk | input | 1 | Serial clock; bits are taken on its rising edge |
| serData | input | 1 | Serial data; the marker bit comes first, then data bit 1 |
| dataEn | input | 1 | Shift enable (1 = shift allowed), used only when NUM_OUT = 34 |
| dispOut | output | NUM_OUT | Latched outputs; bit k-1 carries data bit k |

## Verification
Two frame actions sit closest together: the clear that ends one word and the capture of the next word's marker bit. They fall one serial low phase apart. Back-to-back words are sent with the serial clock held low for only a few system clocks, and with no idle time between words. The bench then checks, in the middle of each following word, that the outputs match the previous word exactly. A missed clear would show as extra ones, or as a load at the wrong time. In the other pairing, data-enable drops on the same serial edge that carries a junk bit, and the reduced variant must still assemble the correct word.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  localparam int SFL_DATA_BITS = 35;
  localparam int SFL_SYNC_STAGES = 2;

  typedef struct packed {
    logic shift;
    logic load;
    logic clear;
  } sfl_strobe_t;
endpackage

// File: rtl/sfl_ctrl.sv
module sfl_ctrl
  import sfl_pkg::*;
#(
  parameter int DATA_BITS = SFL_DATA_BITS,
  parameter int NUM_OUT = SFL_DATA_BITS,
  parameter int SYNC_STAGES = SFL_SYNC_STAGES
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        dataEn,
  input  logic        frameFull,
  output sfl_strobe_t strb,
  output logic        bitIn
);
  localparam int TOP = SYNC_STAGES - 1;
  localparam logic GATED = (NUM_OUT < DATA_BITS);

  logic [TOP:0] clkSync, datSync, enSync;
  logic clkPrev;
  logic loadDone;
  logic riseSeen, fallSeen, shiftOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync <= '0;
      datSync <= '0;
      enSync  <= '0;
      clkPrev <= 1'b0;
    end else begin
      clkSync <= {clkSync[TOP-1:0], serClk};
      datSync <= {datSync[TOP-1:0], serData};
      enSync  <= {enSync[TOP-1:0], dataEn};
      clkPrev <= clkSync[TOP];
    end
  end

  assign riseSeen = clkSync[TOP] & ~clkPrev;
  assign fallSeen = ~clkSync[TOP] & clkPrev;
  assign shiftOk  = enSync[TOP] | ~GATED;
  assign bitIn    = datSync[TOP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loadDone <= 1'b0;
    else if (strb.load) loadDone <= 1'b1;
    else if (strb.clear) loadDone <= 1'b0;
  end

  always_comb begin
    strb.shift = riseSeen & shiftOk;
    strb.load  = frameFull & ~loadDone;
    strb.clear = fallSeen & loadDone;
  end
endmodule

// File: rtl/sfl_datapath.sv
module sfl_datapath
  import sfl_pkg::*;
#(
  parameter int DATA_BITS = SFL_DATA_BITS,
  parameter int NUM_OUT = SFL_DATA_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  sfl_strobe_t        strb,
  input  logic               bitIn,
  output logic               frameFull,
  output logic [NUM_OUT-1:0] dispOut
);
  logic [DATA_BITS:0] stages;
  logic [NUM_OUT-1:0] mapped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stages <= '0;
    else if (strb.clear) stages <= '0;
    else if (strb.shift) stages <= {stages[DATA_BITS-1:0], bitIn};
  end

  assign frameFull = stages[DATA_BITS];

  for (genvar k = 1; k <= NUM_OUT; k++) begin : g_map
    assign mapped[k-1] = stages[DATA_BITS-k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dispOut <= '0;
    else if (strb.load) dispOut <= mapped;
  end
endmodule

// File: rtl/serial_frame_latch.sv
module serial_frame_latch
  import sfl_pkg::*;
#(
  parameter int NUM_OUT = SFL_DATA_BITS,
  parameter int DATA_BITS = SFL_DATA_BITS,
  parameter int SYNC_STAGES = SFL_SYNC_STAGES
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serClk,
  input  logic               serData,
  input  logic               dataEn,
  output logic [NUM_OUT-1:0] dispOut
);
  sfl_strobe_t strb;
  logic frameFull;
  logic bitIn;

  sfl_ctrl #(.DATA_BITS(DATA_BITS), .NUM_OUT(NUM_OUT), .SYNC_STAGES(SYNC_STAGES)) ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .dataEn(dataEn),
    .frameFull(frameFull), .strb(strb), .bitIn(bitIn)
  );

  sfl_datapath #(.DATA_BITS(DATA_BITS), .NUM_OUT(NUM_OUT)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIn(bitIn),
    .frameFull(frameFull), .dispOut(dispOut)
  );
endmodule

// File: rtl/sfl_checker.sv
module sfl_checker
  import sfl_pkg::*;
#(
  parameter int NUM_OUT = SFL_DATA_BITS
) (
  input logic               clk,
  input logic               rstN,
  input sfl_strobe_t        strb,
  input logic               frameFull,
  input logic [NUM_OUT-1:0] dispOut
);
  assert_reset_clear_R1: assert property (@(posedge clk) !rstN |=> dispOut == '0);

  assert_full_loads_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameFull) |-> strb.load);

  assert_hold_between_loads_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(dispOut));

  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> !frameFull);

  assert_single_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !strb.load);
endmodule

bind serial_frame_latch sfl_checker #(.NUM_OUT(NUM_OUT)) sflChk (
  .clk(clk), .rstN(rstN), .strb(strb), .frameFull(frameFull), .dispOut(dispOut)
);

// File: tb/serial_frame_latch_test.sv
module serial_frame_latch_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic dataEn = 1'b0;
  logic [34:0] out35;
  logic [33:0] out34;
  logic [34:0] exp35 = '0;
  logic [33:0] exp34 = '0;
  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  serial_frame_latch uut (.clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
                          .dataEn(dataEn), .dispOut(out35));
  serial_frame_latch #(.NUM_OUT(34)) uut34 (.clk(clk), .rstN(rstN), .serClk(serClk),
                          .serData(serData), .dataEn(dataEn), .dispOut(out34));

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] expv);
    nCmp++;
    if (act !== expv) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic checkBoth(input string tag35, input string tag34);
    check(tag35, out35, exp35);
    check(tag34, {1'b0, out34}, {1'b0, exp34});
  endtask

  task automatic sendBit(input logic b, input logic en, input int half);
    @(negedge clk);
    serData = b;
    dataEn = en;
    repeat (half) @(negedge clk);
    serClk = 1'b1;
    repeat (half) @(negedge clk);
    serClk = 1'b0;
  endtask

  // marker, then bits[0] (= data bit 1) .. bits[34]
  task automatic sendFrame(input logic [34:0] bits, input logic en, input int half,
                           input int gap, input bit load34);
    sendBit(1'b1, en, half);
    for (int i = 0; i < 35; i++) begin
      sendBit(bits[i], en, half);
      if (i == 20) checkBoth("R3 hold mid-word (full)", "R3 hold mid-word (reduced)");
    end
    exp35 = bits;
    if (load34) exp34 = bits[33:0];
    if (gap > 0) begin
      repeat (gap) @(negedge clk);
      checkBoth("R2/R10 load (full)", "R2/R9 load (reduced)");
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    exp35 = '0;
    exp34 = '0;
    checkBoth("R1 during reset (full)", "R1 during reset (reduced)");
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    checkBoth("R1 after reset (full)", "R1 after reset (reduced)");
  endtask

  initial begin
    logic [34:0] pat;
    doReset();

    // R2 R9 R10: walking one across every data bit position
    for (int k = 0; k < 35; k++) sendFrame(35'd1 << k, 1'b1, 4, 8, 1'b1);

    // R5: back-to-back words with short low phases, checked by next word's mid check
    pat = 35'h2_5A5A_5A5A;
    for (int n = 0; n < 8; n++) begin
      sendFrame(pat, 1'b1, 2, 0, 1'b1);
      pat = pat * 35'd1103515245 + 35'd12345;
    end
    sendFrame(35'h7_FFFF_FFFF, 1'b1, 2, 8, 1'b1);
    sendFrame(35'h0, 1'b1, 3, 8, 1'b1);

    // R8 and R7: enable low -> full loads, reduced ignores every edge
    sendFrame(35'h5_1234_ABCD, 1'b0, 3, 8, 1'b0);
    check("R7 reduced ignored with enable low", {1'b0, out34}, 35'h0);
    sendFrame(35'h3_0F0F_1E1E, 1'b1, 3, 8, 1'b1);

    // R7: word interleaved with junk edges at enable low (reduced only)
    doReset();
    pat = 35'h6_CAFE_1357;
    sendBit(1'b1, 1'b0, 2);
    sendBit(1'b1, 1'b1, 2);
    for (int i = 0; i < 35; i++) begin
      sendBit(1'b1, 1'b0, 2);
      sendBit(pat[i], 1'b1, 2);
    end
    repeat (8) @(negedge clk);
    check("R7 interleaved word (reduced)", {1'b0, out34}, {1'b0, pat[33:0]});
    doReset();

    // R4: word cut short loads nothing
    sendFrame(35'h1_1111_1111, 1'b1, 3, 8, 1'b1);
    sendBit(1'b1, 1'b1, 3);
    for (int i = 0; i < 12; i++) sendBit(1'b0, 1'b1, 3);
    repeat (12) @(negedge clk);
    checkBoth("R4 partial word (full)", "R4 partial word (reduced)");
    doReset();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule